// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block picks the instructions that leave an out-of-order issue queue in one cycle. Five ready lists feed it: integer, floating point, branch, memory and miscellaneous. Each list shows a window of its oldest ready entries. An entry carries a valid bit, a sequence number and a squashed flag. The lists are kept in age order, so entry 0 of a window is that list's oldest entry. The selector runs a fixed number of selection rounds. In each round it picks the oldest head among the classes that may still issue and places that head in the next issue slot.

Squashed entries are popped as they reach the head of a class that is still eligible. They take no slot and no class quota. The per-class pop counts are combinational, so the lists can advance in the same cycle. The issue slots, their valid bits and the slot count are registered and appear one clock later. Each issued slot also returns one free queue entry to the queue's credit logic.

Top module: `iss_sel_top`

## Requirements
- R1: At most ISSUE_W instructions are issued per cycle, and `slot_cnt` never exceeds ISSUE_W.
- R2: In one cycle, the integer, float, branch and memory classes issue at most CAP_INT, CAP_FP, CAP_BR and CAP_MEM instructions. A class that has reached its cap offers nothing more that cycle.
- R3: The miscellaneous class has no cap of its own. It can fill every slot up to ISSUE_W.
- R4: Each round issues the offered head with the smallest sequence number. When sequence numbers are equal, the class with the lower code wins. The class codes on `slot_cls` are integer 0, float 1, branch 2, memory 3 and misc 4.
- R5: Issued instructions fill slots 0, 1, 2, … in the order they were selected, with no gaps. `slot_vld` marks the filled slots and `slot_cnt` equals the number of set bits. These outputs change only at a clock edge: they reflect the inputs of the previous cycle.
- R6: A squashed entry at the head of an eligible class is popped and takes neither a slot nor class quota. Squashed entries in a class that has reached its cap stay unpopped.
- R7: `pop_cnt` for a class equals the number of that class's entries issued plus the number discarded as squashed in the same cycle. It is valid combinationally in that cycle.
- R8: When no list has a valid entry, all pop counts are zero and the next `slot_cnt` is zero.
- R9: An asynchronous active-low reset clears `slot_vld` and `slot_cnt` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_vld | input | NCLS*WIN | Valid bit of entry j of class c, at bit c*WIN+j |
| cand_sqd | input | NCLS*WIN | Squashed flag of each window entry, same layout |
| cand_seq | input | NCLS*WIN*SEQ_W | Sequence number of each window entry, field c*WIN+j |
| pop_cnt | output | NCLS*PTR_W | Entries to pop from each class this cycle, field c |
| slot_vld | output | ISSUE_W | Registered valid bit per issue slot |
| slot_cls | output | ISSUE_W*CLS_W | Registered class code per slot |
| slot_seq | output | ISSUE_W*SEQ_W | Registered sequence number per slot |
| slot_cnt | output | CNT_W | Registered number of filled slots, which is also the free entries returned |

## Verification
The bound checker checks the following on every cycle:
- the width bound;
- the gap-free slot prefix and its match with the count;
- each class cap, counted over the registered slots;
- sequence numbers that never decrease across filled slots;
- zero pops on an empty input;
- pops that are never fewer than the next cycle's issues.

Some behaviours can only be shown by the bench's scenarios, because they depend on knowing which entries were offered:
- which class wins a tie;
- exactly how many squashed entries are discarded;
- that a capped class leaves its squashed entries in place;
- the exact slot contents.

// File: rtl/iss_pkg.sv
package iss_pkg;
   localparam int NCLS  = 5;
   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_INT  = 3'd0,
      CLS_FP   = 3'd1,
      CLS_BR   = 3'd2,
      CLS_MEM  = 3'd3,
      CLS_MISC = 3'd4
   } iss_cls_e;
endpackage

// File: rtl/iss_head_scan.sv
// Finds, from the class pointer onward, the first live entry. Squashed
// entries passed over are counted as popped by the caller.
module iss_head_scan #(
   parameter int WIN   = 4,
   parameter int PTR_W = 3
) (
   input  logic [WIN-1:0]   vld,
   input  logic [WIN-1:0]   sqd,
   input  logic [PTR_W-1:0] ptr,
   output logic [PTR_W-1:0] nxt,
   output logic             found
);
   always_comb begin
      nxt   = PTR_W'(WIN);
      found = 1'b0;
      for (int j = WIN - 1; j >= 0; j--) begin
         if (PTR_W'(j) >= ptr && (!vld[j] || !sqd[j])) begin
            nxt   = PTR_W'(j);
            found = vld[j];
         end
      end
   end
endmodule

// File: rtl/iss_age_pick.sv
// Oldest offered head wins; a later class must be strictly older.
module iss_age_pick #(
   parameter int NCLS  = 5,
   parameter int SEQ_W = 8,
   parameter int CLS_W = 3
) (
   input  logic [NCLS-1:0]       ofr,
   input  logic [NCLS*SEQ_W-1:0] seq,
   output logic                  hit,
   output logic [CLS_W-1:0]      cls,
   output logic [SEQ_W-1:0]      seq_o
);
   always_comb begin
      hit   = 1'b0;
      cls   = '0;
      seq_o = '0;
      for (int c = 0; c < NCLS; c++) begin
         if (ofr[c] && (!hit || seq[c*SEQ_W +: SEQ_W] < seq_o)) begin
            hit   = 1'b1;
            cls   = CLS_W'(c);
            seq_o = seq[c*SEQ_W +: SEQ_W];
         end
      end
   end
endmodule

// File: rtl/iss_sel_top.sv
module iss_sel_top
   import iss_pkg::*;
#(
   parameter int SEQ_W   = 8,
   parameter int WIN     = 4,
   parameter int ISSUE_W = 4,
   parameter int CAP_INT = 2,
   parameter int CAP_FP  = 1,
   parameter int CAP_BR  = 1,
   parameter int CAP_MEM = 1,
   localparam int PTR_W  = $clog2(WIN + 1),
   localparam int CNT_W  = $clog2(ISSUE_W + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NCLS*WIN-1:0]       cand_vld,
   input  logic [NCLS*WIN-1:0]       cand_sqd,
   input  logic [NCLS*WIN*SEQ_W-1:0] cand_seq,
   output logic [NCLS*PTR_W-1:0]     pop_cnt,
   output logic [ISSUE_W-1:0]        slot_vld,
   output logic [ISSUE_W*CLS_W-1:0]  slot_cls,
   output logic [ISSUE_W*SEQ_W-1:0]  slot_seq,
   output logic [CNT_W-1:0]          slot_cnt
);
   function automatic int cls_cap(input int c);
      case (c)
         0:       return CAP_INT;
         1:       return CAP_FP;
         2:       return CAP_BR;
         3:       return CAP_MEM;
         default: return ISSUE_W;
      endcase
   endfunction

   if (WIN < 1 || SEQ_W < 1 || ISSUE_W < 1) begin : g_bad_size
      $error("iss_sel_top: WIN, SEQ_W and ISSUE_W must be at least 1");
   end
   for (genvar k = 0; k < 4; k++) begin : g_cap_chk
      if (cls_cap(k) < 1 || cls_cap(k) > ISSUE_W) begin : g_bad_cap
         $error("iss_sel_top: class caps must lie in 1..ISSUE_W");
      end
   end

   logic [ISSUE_W-1:0]       nx_vld;
   logic [ISSUE_W*CLS_W-1:0] nx_cls;
   logic [ISSUE_W*SEQ_W-1:0] nx_seq;
   logic [CNT_W-1:0]         nx_cnt;

   for (genvar r = 0; r < ISSUE_W; r++) begin : g_rnd
      logic [NCLS*PTR_W-1:0] p_in, p_out;
      logic [NCLS*CNT_W-1:0] c_in, c_out;
      logic [NCLS-1:0]       ofr;
      logic [NCLS*SEQ_W-1:0] hseq;
      logic                  hit;
      logic [CLS_W-1:0]      wcls;
      logic [SEQ_W-1:0]      wseq;

      if (r == 0) begin : g_first
         assign p_in = '0;
         assign c_in = '0;
      end else begin : g_next
         assign p_in = g_rnd[r-1].p_out;
         assign c_in = g_rnd[r-1].c_out;
      end

      for (genvar c = 0; c < NCLS; c++) begin : g_cls
         logic             elig, found, take;
         logic [PTR_W-1:0] skp;
         logic [CNT_W-1:0] cur;
         logic [SEQ_W-1:0] hs;

         assign cur = c_in[c*CNT_W +: CNT_W];

         if (c == int'(CLS_MISC)) begin : g_free
            assign elig = 1'b1;
         end else begin : g_capped
            assign elig = cur < CNT_W'(cls_cap(c));
         end

         iss_head_scan #(.WIN(WIN), .PTR_W(PTR_W)) u_scan (
            .vld   (cand_vld[c*WIN +: WIN]),
            .sqd   (cand_sqd[c*WIN +: WIN]),
            .ptr   (p_in[c*PTR_W +: PTR_W]),
            .nxt   (skp),
            .found (found)
         );

         always_comb begin
            hs = '0;
            for (int j = 0; j < WIN; j++) begin
               if (skp == PTR_W'(j)) hs = cand_seq[(c*WIN + j)*SEQ_W +: SEQ_W];
            end
         end

         assign ofr[c]                  = elig & found;
         assign hseq[c*SEQ_W +: SEQ_W]  = hs;
         assign take                    = hit && (wcls == CLS_W'(c));
         assign p_out[c*PTR_W +: PTR_W] = elig ? skp + PTR_W'(take)
                                               : p_in[c*PTR_W +: PTR_W];
         assign c_out[c*CNT_W +: CNT_W] = cur + CNT_W'(take);
      end

      iss_age_pick #(.NCLS(NCLS), .SEQ_W(SEQ_W), .CLS_W(CLS_W)) u_pick (
         .ofr   (ofr),
         .seq   (hseq),
         .hit   (hit),
         .cls   (wcls),
         .seq_o (wseq)
      );

      assign nx_vld[r]                  = hit;
      assign nx_cls[r*CLS_W +: CLS_W]   = wcls;
      assign nx_seq[r*SEQ_W +: SEQ_W]   = wseq;
   end

   assign pop_cnt = g_rnd[ISSUE_W-1].p_out;

   always_comb begin
      nx_cnt = '0;
      for (int r = 0; r < ISSUE_W; r++) nx_cnt = nx_cnt + CNT_W'(nx_vld[r]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_vld <= '0;
         slot_cls <= '0;
         slot_seq <= '0;
         slot_cnt <= '0;
      end else begin
         slot_vld <= nx_vld;
         slot_cls <= nx_cls;
         slot_seq <= nx_seq;
         slot_cnt <= nx_cnt;
      end
   end
endmodule

// File: rtl/iss_sel_chk.sv
module iss_sel_chk
   import iss_pkg::*;
#(
   parameter int SEQ_W   = 8,
   parameter int WIN     = 4,
   parameter int ISSUE_W = 4,
   parameter int CAP_INT = 2,
   parameter int CAP_FP  = 1,
   parameter int CAP_BR  = 1,
   parameter int CAP_MEM = 1,
   localparam int PTR_W  = $clog2(WIN + 1),
   localparam int CNT_W  = $clog2(ISSUE_W + 1),
   localparam int SUM_W  = PTR_W + 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NCLS*WIN-1:0]      cand_vld,
   input logic [NCLS*PTR_W-1:0]    pop_cnt,
   input logic [ISSUE_W-1:0]       slot_vld,
   input logic [ISSUE_W*CLS_W-1:0] slot_cls,
   input logic [ISSUE_W*SEQ_W-1:0] slot_seq,
   input logic [CNT_W-1:0]         slot_cnt
);
   localparam int CAPS [4] = '{CAP_INT, CAP_FP, CAP_BR, CAP_MEM};

   logic [CNT_W-1:0] ccnt [4];
   logic [SUM_W-1:0] psum;

   always_comb begin
      for (int c = 0; c < 4; c++) begin
         ccnt[c] = '0;
         for (int s = 0; s < ISSUE_W; s++) begin
            if (slot_vld[s] && slot_cls[s*CLS_W +: CLS_W] == CLS_W'(c))
               ccnt[c] = ccnt[c] + CNT_W'(1);
         end
      end
      psum = '0;
      for (int c = 0; c < NCLS; c++) psum = psum + SUM_W'(pop_cnt[c*PTR_W +: PTR_W]);
   end

   p_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
      slot_cnt <= CNT_W'(ISSUE_W));

   p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(slot_vld) == int'(slot_cnt));

   for (genvar s = 1; s < ISSUE_W; s++) begin : g_slot
      p_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n)
         slot_vld[s] |-> slot_vld[s-1]);
      p_age_r4: assert property (@(posedge clk) disable iff (!rst_n)
         slot_vld[s] |-> slot_seq[(s-1)*SEQ_W +: SEQ_W] <= slot_seq[s*SEQ_W +: SEQ_W]);
   end

   for (genvar c = 0; c < 4; c++) begin : g_cap
      p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
         ccnt[c] <= CNT_W'(CAPS[c]));
   end

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_vld == '0) |-> (pop_cnt == '0));

   p_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> SUM_W'(slot_cnt) <= $past(psum));
endmodule

bind iss_sel_top iss_sel_chk #(
   .SEQ_W(SEQ_W), .WIN(WIN), .ISSUE_W(ISSUE_W),
   .CAP_INT(CAP_INT), .CAP_FP(CAP_FP), .CAP_BR(CAP_BR), .CAP_MEM(CAP_MEM)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cand_vld (cand_vld),
   .pop_cnt  (pop_cnt),
   .slot_vld (slot_vld),
   .slot_cls (slot_cls),
   .slot_seq (slot_seq),
   .slot_cnt (slot_cnt)
);

// File: tb/iss_sel_top_tb.sv
`timescale 1ns/1ps
module iss_sel_top_tb;
   localparam int NC = 5, WN = 4, SW = 8, IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [19:0]   cand_vld = '0, cand_sqd = '0;
   logic [159:0]  cand_seq = '0;
   logic [14:0]   pop_cnt;
   logic [3:0]    slot_vld;
   logic [11:0]   slot_cls;
   logic [31:0]   slot_seq;
   logic [2:0]    slot_cnt;

   always #2.5 clk = ~clk;

   iss_sel_top u_dut (
      .clk(clk), .rst_n(rst_n), .cand_vld(cand_vld), .cand_sqd(cand_sqd),
      .cand_seq(cand_seq), .pop_cnt(pop_cnt), .slot_vld(slot_vld),
      .slot_cls(slot_cls), .slot_seq(slot_seq), .slot_cnt(slot_cnt)
   );

   // Class fields packed {misc,mem,br,fp,int}; slot fields {s3,s2,s1,s0}.
   // Entry j of a class has sequence number base + 10*j.
   typedef struct packed {
      logic [14:0] nval;
      logic [39:0] base;
      logic [19:0] sqm;
      logic [2:0]  ecnt;
      logic [11:0] ecls;
      logic [31:0] eseq;
      logic [14:0] epop;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t TBL [NV] = '{
      // V0 empty lists: nothing issued, no pops (R8)
      '{15'd0, 40'd0, 20'd0, 3'd0, 12'd0, 32'd0, 15'd0},
      // V1 integer only, cap of 2 stops it (R2)
      '{{3'd0,3'd0,3'd0,3'd0,3'd4}, {8'd0,8'd0,8'd0,8'd0,8'd5}, 20'd0, 3'd2,
        {3'd0,3'd0,3'd0,3'd0}, {8'd0,8'd0,8'd15,8'd5}, {3'd0,3'd0,3'd0,3'd0,3'd2}},
      // V2 misc only fills all slots (R3)
      '{{3'd4,3'd0,3'd0,3'd0,3'd0}, {8'd1,8'd0,8'd0,8'd0,8'd0}, 20'd0, 3'd4,
        {3'd4,3'd4,3'd4,3'd4}, {8'd31,8'd21,8'd11,8'd1}, {3'd4,3'd0,3'd0,3'd0,3'd0}},
      // V3 global age order across classes (R4, R1)
      '{{3'd1,3'd2,3'd1,3'd1,3'd2}, {8'd25,8'd5,8'd20,8'd10,8'd30}, 20'd0, 3'd4,
        {3'd4,3'd2,3'd1,3'd3}, {8'd25,8'd20,8'd10,8'd5}, {3'd1,3'd1,3'd1,3'd1,3'd0}},
      // V4 equal ages: int, then float, then misc (R4)
      '{{3'd1,3'd0,3'd0,3'd1,3'd1}, {8'd7,8'd0,8'd0,8'd7,8'd7}, 20'd0, 3'd3,
        {3'd0,3'd4,3'd1,3'd0}, {8'd0,8'd7,8'd7,8'd7}, {3'd1,3'd0,3'd0,3'd1,3'd1}},
      // V5 two squashed int heads discarded for free (R6, R7)
      '{{3'd0,3'd0,3'd0,3'd1,3'd3}, {8'd0,8'd0,8'd0,8'd50,8'd2},
        {4'd0,4'd0,4'd0,4'd0,4'b0011}, 3'd2,
        {3'd0,3'd0,3'd1,3'd0}, {8'd0,8'd0,8'd50,8'd22}, {3'd0,3'd0,3'd0,3'd1,3'd3}},
      // V6 squashed entry behind a capped class stays (R6)
      '{{3'd0,3'd0,3'd0,3'd1,3'd4}, {8'd0,8'd0,8'd0,8'd60,8'd1},
        {4'd0,4'd0,4'd0,4'd0,4'b0100}, 3'd3,
        {3'd0,3'd1,3'd0,3'd0}, {8'd0,8'd60,8'd11,8'd1}, {3'd0,3'd0,3'd0,3'd1,3'd2}},
      // V7 whole misc window squashed: popped, no slot used (R6, R7)
      '{{3'd4,3'd0,3'd0,3'd0,3'd1}, {8'd0,8'd0,8'd0,8'd0,8'd9},
        {4'b1111,4'd0,4'd0,4'd0,4'd0}, 3'd1,
        {3'd0,3'd0,3'd0,3'd0}, {8'd0,8'd0,8'd0,8'd9}, {3'd4,3'd0,3'd0,3'd0,3'd1}},
      // V8 mixed classes reach the total width (R1, R2, R4)
      '{{3'd2,3'd0,3'd1,3'd2,3'd3}, {8'd3,8'd0,8'd40,8'd2,8'd1}, 20'd0, 3'd4,
        {3'd0,3'd4,3'd1,3'd0}, {8'd11,8'd3,8'd2,8'd1}, {3'd1,3'd0,3'd0,3'd1,3'd2}}
   };

   int  total = 0, fails = 0;
   bit  done = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      for (int c = 0; c < NC; c++) begin
         for (int j = 0; j < WN; j++) begin
            cand_vld[c*WN + j] = (j < int'(v.nval[c*3 +: 3]));
            cand_sqd[c*WN + j] = v.sqm[c*WN + j];
            cand_seq[(c*WN + j)*SW +: SW] = v.base[c*SW +: SW] + 8'(10*j);
         end
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      logic [2:0] prev_cnt;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9", "slot_cnt in reset", 32'(slot_cnt), 32'd0);
      chk("R9", "slot_vld in reset", 32'(slot_vld), 32'd0);
      rst_n = 1'b1;
      prev_cnt = 3'd0;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(TBL[i]);
         #1;
         chk("R7", $sformatf("pop_cnt V%0d", i), 32'(pop_cnt), 32'(TBL[i].epop));
         chk("R5", $sformatf("held slot_cnt V%0d", i), 32'(slot_cnt), 32'(prev_cnt));
         @(posedge clk);
         #1;
         chk("R1", $sformatf("slot_cnt V%0d", i), 32'(slot_cnt), 32'(TBL[i].ecnt));
         chk("R5", $sformatf("slot_vld V%0d", i), 32'(slot_vld),
             32'((1 << TBL[i].ecnt) - 1));
         for (int s = 0; s < IW; s++) begin
            if (s < int'(TBL[i].ecnt)) begin
               chk("R4", $sformatf("slot %0d class V%0d", s, i),
                   32'(slot_cls[s*3 +: 3]), 32'(TBL[i].ecls[s*3 +: 3]));
               chk("R4", $sformatf("slot %0d seq V%0d", s, i),
                   32'(slot_seq[s*SW +: SW]), 32'(TBL[i].eseq[s*SW +: SW]));
            end
         end
         prev_cnt = TBL[i].ecnt;
      end
      // Asynchronous reset clears a full set of slots between edges (R9)
      @(negedge clk);
      apply(TBL[2]);
      @(posedge clk);
      #1;
      chk("R3", "misc full before reset", 32'(slot_cnt), 32'd4);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R9", "slot_cnt after async reset", 32'(slot_cnt), 32'd0);
      chk("R9", "slot_vld after async reset", 32'(slot_vld), 32'd0);
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual running expected done");
         finish_run();
      end
   end
endmodule